// File: doc/BRIEF.md
# Trace Synchronisation Scheduler

This block decides when a trace encoder has to emit a synchronisation packet and whether the encoder is allowed to run at all. While the encoder runs, an interval counter advances on every clock cycle or on every emitted packet, chosen by a mode input. When the count reaches a programmable threshold, the block raises a one-cycle sync request and the counter starts again from zero.

The block also handles recovery after a packet is lost. A loss stops the encoder. If automatic restart is enabled, the block waits until the encoder's output FIFO reports empty. It then enables the encoder again and requests a sync packet before any normal traffic. If automatic restart is disabled, the encoder stays stopped until a new start trigger arrives.

Every entry into the running state, whether from a start trigger or from a restart, comes with a sync request and clears the interval counter. Packet formatting is handled outside this block.

Top module: `trace_sync_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `enc_en_o` and `sync_req_o` are both low.
- R2: A `start_i` pulse while the encoder is stopped raises `enc_en_o` in the next cycle, with `sync_req_o` high in that same cycle. A `start_i` pulse while the encoder runs has no effect and does not shift the interval.
- R3: With `cfg_count_pkts_i` low, `sync_req_o` pulses every T clock cycles for a threshold T. The interval is counted from the previous sync pulse, whether that pulse came from a start, a restart or the threshold.
- R4: With `cfg_count_pkts_i` high, `sync_req_o` pulses in the cycle after the T-th `pkt_sent_i` strobe since the previous sync pulse. Cycles without a strobe are not counted.
- R5: Threshold values 0 and 1 behave exactly like 2.
- R6: `sync_req_o` is never high for two cycles in a row, and it is high only while `enc_en_o` is high.
- R7: A `pkt_lost_i` strobe while the encoder runs drives `enc_en_o` low in the next cycle, with no sync request.
- R8: With `cfg_auto_restart_i` high, the encoder stays stopped after a loss for as long as `fifo_empty_i` is low. In the cycle after the first cycle in which `fifo_empty_i` is high, `enc_en_o` and `sync_req_o` both go high.
- R9: With `cfg_auto_restart_i` low, the encoder stays stopped after a loss whatever the value of `fifo_empty_i`, until a `start_i` pulse restarts it together with a sync request.
- R10: `stop_i` drives `enc_en_o` low in the next cycle. It takes priority over `start_i` and `pkt_lost_i` in the same cycle. A stop never leads to an automatic restart.
- R11: While the encoder is stopped and no loss is pending, `pkt_sent_i`, `pkt_lost_i` and `fifo_empty_i` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start trigger pulse |
| stop_i | input | 1 | Stop trigger pulse |
| pkt_sent_i | input | 1 | Strobe: encoder emitted a packet |
| pkt_lost_i | input | 1 | Strobe: a packet was lost |
| fifo_empty_i | input | 1 | Output FIFO of the encoder is empty |
| cfg_thresh_i | input | THR_W | Resync threshold |
| cfg_count_pkts_i | input | 1 | 0: count clock cycles, 1: count emitted packets |
| cfg_auto_restart_i | input | 1 | Automatic restart after a loss |
| sync_req_o | output | 1 | One-cycle sync packet request |
| enc_en_o | output | 1 | Encoder enable |

## Verification
The assertions assume that `fifo_empty_i` is low whenever a restart must not happen. They also assume that a loss is reported only as a strobe while the encoder runs. Under these assumptions, the only ways for the encoder to leave the stopped state are a start trigger or an empty FIFO. The stimulus keeps `fifo_empty_i` low during the drain waits and raises it only at the moment a restart is intended. The bench sweeps the threshold over the small values 0 to 9, and in packet mode it varies the spacing between strobes. The expected pulse cycles are computed arithmetically from the effective threshold.

// File: rtl/trace_sync_pkg.sv
package trace_sync_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } run_state_e;

   localparam int MIN_INTERVAL = 2;
endpackage

// File: rtl/trace_sync_ctrl.sv
module trace_sync_ctrl
   import trace_sync_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic stop_i,
   input  logic lost_i,
   input  logic fifo_empty_i,
   input  logic auto_restart_i,
   output logic run_o,
   output logic advance_o,
   output logic launch_o
);
   run_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      launch_o = 1'b0;
      if (stop_i) begin
         state_d = ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               if (start_i) begin
                  state_d  = ST_RUN;
                  launch_o = 1'b1;
               end
            end
            ST_RUN: begin
               if (lost_i) state_d = auto_restart_i ? ST_DRAIN : ST_OFF;
            end
            ST_DRAIN: begin
               if (start_i || fifo_empty_i) begin
                  state_d  = ST_RUN;
                  launch_o = 1'b1;
               end
            end
            default: state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_OFF;
      else         state_q <= state_d;
   end

   assign run_o     = (state_q == ST_RUN);
   assign advance_o = run_o && !stop_i && !lost_i;
endmodule

// File: rtl/trace_sync_event_sel.sv
module trace_sync_event_sel #(
   parameter bit PKT_MODE_EN = 1'b1
) (
   input  logic count_pkts_i,
   input  logic pkt_sent_i,
   output logic event_o
);
   generate
      if (PKT_MODE_EN) begin : g_selectable
         assign event_o = count_pkts_i ? pkt_sent_i : 1'b1;
      end else begin : g_cycles_only
         assign event_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/trace_sync_interval.sv
module trace_sync_interval
   import trace_sync_pkg::*;
#(
   parameter int THR_W = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             advance_i,
   input  logic             event_i,
   input  logic [THR_W-1:0] thresh_i,
   output logic             hit_o
);
   localparam logic [THR_W-1:0] FLOOR = THR_W'(MIN_INTERVAL);

   logic [THR_W-1:0] cnt_q;
   logic [THR_W-1:0] eff_thr;
   logic [THR_W:0]   cnt_inc;

   assign eff_thr = (thresh_i < FLOOR) ? FLOOR : thresh_i;
   assign cnt_inc = {1'b0, cnt_q} + (THR_W+1)'(1);
   assign hit_o   = advance_i && event_i && (cnt_inc >= {1'b0, eff_thr});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cnt_q <= '0;
      else if (clear_i || hit_o)      cnt_q <= '0;
      else if (advance_i && event_i)  cnt_q <= cnt_inc[THR_W-1:0];
   end
endmodule

// File: rtl/trace_sync_sched.sv
module trace_sync_sched #(
   parameter int THR_W       = 24,
   parameter bit PKT_MODE_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             pkt_sent_i,
   input  logic             pkt_lost_i,
   input  logic             fifo_empty_i,
   input  logic [THR_W-1:0] cfg_thresh_i,
   input  logic             cfg_count_pkts_i,
   input  logic             cfg_auto_restart_i,
   output logic             sync_req_o,
   output logic             enc_en_o
);
   generate
      if (THR_W < 2 || THR_W > 32) begin : g_bad_width
         $error("trace_sync_sched: THR_W must lie in 2..32");
      end
   endgenerate

   logic run, advance, launch, evt, hit;
   logic sync_q;

   trace_sync_ctrl i_ctrl (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .start_i        (start_i),
      .stop_i         (stop_i),
      .lost_i         (pkt_lost_i),
      .fifo_empty_i   (fifo_empty_i),
      .auto_restart_i (cfg_auto_restart_i),
      .run_o          (run),
      .advance_o      (advance),
      .launch_o       (launch)
   );

   trace_sync_event_sel #(.PKT_MODE_EN(PKT_MODE_EN)) i_evt (
      .count_pkts_i (cfg_count_pkts_i),
      .pkt_sent_i   (pkt_sent_i),
      .event_o      (evt)
   );

   trace_sync_interval #(.THR_W(THR_W)) i_intv (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (launch),
      .advance_i (advance),
      .event_i   (evt),
      .thresh_i  (cfg_thresh_i),
      .hit_o     (hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= 1'b0;
      else         sync_q <= launch || hit;
   end

   assign sync_req_o = sync_q;
   assign enc_en_o   = run;
endmodule

// File: rtl/trace_sync_sched_chk.sv
module trace_sync_sched_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic start_i,
   input logic stop_i,
   input logic pkt_lost_i,
   input logic fifo_empty_i,
   input logic sync_req_o,
   input logic enc_en_o
);
   // R6
   sync_only_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_req_o |-> enc_en_o);
   // R6
   sync_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_req_o |=> !sync_req_o);
   // R2
   launch_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(enc_en_o) |-> sync_req_o);
   // R10
   stop_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (!enc_en_o && !sync_req_o));
   // R7
   loss_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enc_en_o && pkt_lost_i) |=> !enc_en_o);
   // R8
   wait_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enc_en_o && !start_i && !fifo_empty_i) |=> !enc_en_o);
endmodule

bind trace_sync_sched trace_sync_sched_chk i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .start_i      (start_i),
   .stop_i       (stop_i),
   .pkt_lost_i   (pkt_lost_i),
   .fifo_empty_i (fifo_empty_i),
   .sync_req_o   (sync_req_o),
   .enc_en_o     (enc_en_o)
);

// File: tb/test_trace_sync_sched.sv
module test_trace_sync_sched;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 50000;

   logic        clk = 1'b0;
   logic        rst_n, start, stop, sent, lost, fe, mode, autor;
   logic [23:0] thr;
   logic        sync, en;
   int          nchk = 0;
   int          nerr = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_sync_sched i_trace_sync_sched (
      .clk_i              (clk),
      .rst_ni             (rst_n),
      .start_i            (start),
      .stop_i             (stop),
      .pkt_sent_i         (sent),
      .pkt_lost_i         (lost),
      .fifo_empty_i       (fe),
      .cfg_thresh_i       (thr),
      .cfg_count_pkts_i   (mode),
      .cfg_auto_restart_i (autor),
      .sync_req_o         (sync),
      .enc_en_o           (en)
   );

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic launch(input string req);
      start = 1'b1;
      cyc();
      start = 1'b0;
      check({req, " enable on start"}, int'(en), 1);
      check({req, " sync on start"}, int'(sync), 1);
   endtask

   task automatic halt();
      stop = 1'b1;
      cyc();
      stop = 1'b0;
      check("R10 stop clears enable", int'(en), 0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; stop = 1'b0; sent = 1'b0; lost = 1'b0;
      fe = 1'b0; mode = 1'b0; autor = 1'b1; thr = 24'd128;
      repeat (3) cyc();
      check("R1 enable in reset", int'(en), 0);
      check("R1 sync in reset", int'(sync), 0);
      rst_n = 1'b1;
      cyc();
      check("R1 enable after reset", int'(en), 0);
      check("R1 sync after reset", int'(sync), 0);

      // R3 / R5 / R2: cycle-mode sweep, with an ignored start inside the interval
      mode = 1'b0;
      for (int t = 0; t < 10; t++) begin
         int te;
         te  = (t < 2) ? 2 : t;
         thr = 24'(t);
         launch("R2");
         for (int k = 1; k <= 3*te; k++) begin
            if (k == 1) start = 1'b1;
            cyc();
            start = 1'b0;
            check((t < 2) ? "R5 small threshold interval" : "R3 cycle interval",
                  int'(sync), (k % te == 0) ? 1 : 0);
            check("R6 enable held while running", int'(en), 1);
         end
         halt();
      end

      // R4 / R5: packet-mode sweep over thresholds and strobe spacings
      mode = 1'b1;
      for (int t = 0; t < 7; t++) begin
         for (int p = 1; p <= 3; p++) begin
            int te;
            int cntm;
            bit exph;
            te   = (t < 2) ? 2 : t;
            thr  = 24'(t);
            cntm = 0;
            launch("R4");
            for (int j = 0; j < 4*te*p; j++) begin
               sent = (j % p == 0);
               exph = sent && (cntm + 1 >= te);
               if (exph) cntm = 0;
               else if (sent) cntm++;
               cyc();
               sent = 1'b0;
               check((t < 2) ? "R5 packet small threshold" : "R4 packet interval",
                     int'(sync), int'(exph));
            end
            halt();
         end
      end

      // R7 / R8: loss with automatic restart
      mode = 1'b0; thr = 24'd4; autor = 1'b1; fe = 1'b0;
      launch("R8");
      cyc(); cyc();
      lost = 1'b1;
      cyc();
      lost = 1'b0;
      check("R7 loss stops encoder", int'(en), 0);
      check("R7 no sync on loss", int'(sync), 0);
      for (int k = 0; k < 5; k++) begin
         cyc();
         check("R8 waits for empty fifo", int'(en), 0);
      end
      fe = 1'b1;
      cyc();
      fe = 1'b0;
      check("R8 restart enable", int'(en), 1);
      check("R8 restart sync", int'(sync), 1);
      for (int k = 1; k <= 8; k++) begin
         cyc();
         check("R3 interval after restart", int'(sync), (k % 4 == 0) ? 1 : 0);
      end

      // R9: loss without automatic restart
      autor = 1'b0;
      lost  = 1'b1;
      cyc();
      lost = 1'b0;
      fe   = 1'b1;
      check("R9 loss stops encoder", int'(en), 0);
      for (int k = 0; k < 6; k++) begin
         cyc();
         check("R9 stays stopped with empty fifo", int'(en), 0);
      end
      fe = 1'b0;
      launch("R9");
      autor = 1'b1;

      // R10: stop beats loss and start, no restart afterwards
      stop = 1'b1; lost = 1'b1; fe = 1'b1;
      cyc();
      stop = 1'b0; lost = 1'b0;
      check("R10 stop wins over loss", int'(en), 0);
      for (int k = 0; k < 4; k++) begin
         cyc();
         check("R10 no restart after stop", int'(en), 0);
      end
      stop = 1'b1; start = 1'b1;
      cyc();
      stop = 1'b0; start = 1'b0;
      check("R10 stop wins over start", int'(en), 0);

      // R11: stimulus while stopped is ignored
      sent = 1'b1; lost = 1'b1; fe = 1'b1;
      for (int k = 0; k < 5; k++) begin
         cyc();
         check("R11 idle enable", int'(en), 0);
         check("R11 idle sync", int'(sync), 0);
      end
      sent = 1'b0; lost = 1'b0; fe = 1'b0;
      cyc();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule